// File: doc/BRIEF.md
# Clock Setting Key Controller

This block turns three debounced pushbutton levels into the control signals of a 24-hour BCD clock with an alarm. A mode key moves the clock between running, setting the alarm and setting the current time. In either setting function, a select key chooses between the hour field and the minute field, and two indicator LEDs show the choice. A change key asks for one increment of the chosen field. When the change key is held down, the increments repeat at the rate of the slow tick.

All logic runs on one system clock. The slow time base arrives as a one-cycle `tick` enable, nominally at 4 Hz. Key edges are found synchronously. Every request leaves the block as a registered one-cycle strobe, never as a derived clock, so the BCD counters downstream can use the strobes directly as count enables. In run mode, holding the select key raises a request to hold the seconds count at zero, which is used to start the clock on an exact second. The BCD counters and the key debouncers are not part of this block.

Top module: `setkey_ctrl`

## Requirements
- R1: After reset, `mode` is 0, the hour field is selected, both LEDs are dark, all four increment strobes are low and `sec_clear` is low.
- R2: Each rising edge of `mode_key` advances `mode` one step along 0 (run) → 1 (alarm set) → 2 (time set) → 0, visible the cycle after the edge. A key held down advances it only once. Value 3 never appears.
- R3: Each rising edge of `sel_key` toggles the selected field between hours and minutes, in every mode.
- R4: In modes 1 and 2, exactly one LED is lit: `led_hour` when hours are selected, `led_min` when minutes are selected. In mode 0 both LEDs are dark.
- R5: In mode 2 the change requests drive `time_hr_inc` or `time_min_inc`. In mode 1 they drive `alarm_hr_inc` or `alarm_min_inc`. The choice follows the selected field.
- R6: A rising edge of `chg_key` in a setting mode gives exactly one strobe, high for one cycle, in the cycle after the edge.
- R7: While `chg_key` stays high, the block counts `tick` pulses up to REPEAT_TICKS. After that many ticks, every further tick gives one strobe in the following cycle, and a cycle without a tick gives none.
- R8: Releasing `chg_key` clears the hold count. The next press again gives a single strobe, and repeat starts only after REPEAT_TICKS more ticks.
- R9: In mode 0, `chg_key` gives no strobe, whether it is pressed once or held across ticks.
- R10: `sec_clear` is high in the cycle after each cycle in which `sel_key` is high and the mode is 0. It is low in every other cycle.
- R11: At most one of the four increment strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle slow time-base enable (nominally 4 Hz) |
| mode_key | input | 1 | Debounced mode key level |
| sel_key | input | 1 | Debounced field-select key level |
| chg_key | input | 1 | Debounced change key level |
| mode | output | 2 | Current function: 0 run, 1 alarm set, 2 time set |
| led_hour | output | 1 | Hour field indicator |
| led_min | output | 1 | Minute field indicator |
| time_hr_inc | output | 1 | Increment strobe for the current-time hours |
| time_min_inc | output | 1 | Increment strobe for the current-time minutes |
| alarm_hr_inc | output | 1 | Increment strobe for the alarm hours |
| alarm_min_inc | output | 1 | Increment strobe for the alarm minutes |
| sec_clear | output | 1 | Request to hold the seconds count at zero |

## Verification
The bench builds the block with REPEAT_TICKS at its default of 3. The bench drives `tick` itself, one pulse at a time, instead of at a real 4 Hz rate, so the switch from single steps to auto-repeat happens within a few dozen cycles. At that value the bench can place ticks exactly around the boundary: it sees three silent ticks, then repeat strobes, then a release, and it checks that the hold count starts again from zero on the next press. Every pairing of setting mode and field is stepped, and run mode is held across ticks to show that no strobe leaks out.

// File: rtl/clkset_pkg.sv
package clkset_pkg;

  typedef enum logic [1:0] {
    MD_RUN   = 2'd0,
    MD_ALARM = 2'd1,
    MD_TIME  = 2'd2
  } mode_e;

  typedef struct packed {
    logic time_hr;
    logic time_min;
    logic alarm_hr;
    logic alarm_min;
  } strobe_t;

  function automatic mode_e mode_after(mode_e m);
    case (m)
      MD_RUN:   return MD_ALARM;
      MD_ALARM: return MD_TIME;
      default:  return MD_RUN;
    endcase
  endfunction

  function automatic strobe_t route(mode_e m, logic fld_min, logic fire);
    strobe_t s;
    s = '0;
    if (fire) begin
      case (m)
        MD_ALARM: begin
          s.alarm_min = fld_min;
          s.alarm_hr  = ~fld_min;
        end
        MD_TIME: begin
          s.time_min = fld_min;
          s.time_hr  = ~fld_min;
        end
        default: s = '0;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/key_edge.sv
module key_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] keys,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_key
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= keys[i];
    end
    assign rise[i] = keys[i] & ~prev_q;
  end
endmodule

// File: rtl/mode_field.sv
module mode_field
  import clkset_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_rise,
  input  logic  sel_rise,
  output mode_e mode_q,
  output logic  fld_min_q,
  output logic  led_hour,
  output logic  led_min
);
  logic setting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_RUN;
      fld_min_q <= 1'b0;
    end else begin
      if (mode_rise) mode_q <= mode_after(mode_q);
      if (sel_rise)  fld_min_q <= ~fld_min_q;
    end
  end

  assign setting  = (mode_q != MD_RUN);
  assign led_hour = setting & ~fld_min_q;
  assign led_min  = setting & fld_min_q;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_rise |=> $stable(mode_q)); // R2
  AST_SEL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> (fld_min_q != $past(fld_min_q))); // R3
  AST_LED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MD_RUN) |-> $onehot({led_hour, led_min})); // R4
endmodule

// File: rtl/repeat_gen.sv
module repeat_gen #(
  parameter int REPEAT_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic chg_key,
  input  logic chg_rise,
  output logic fire
);
  localparam int CNT_W = $clog2(REPEAT_TICKS + 1);
  localparam logic [CNT_W-1:0] REP_C = CNT_W'(REPEAT_TICKS);

  logic [CNT_W-1:0] hold_cnt;
  logic             hold_full;
  logic             repeat_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hold_cnt <= '0;
    else if (!chg_key)                  hold_cnt <= '0;
    else if (tick && hold_cnt != REP_C) hold_cnt <= hold_cnt + 1'b1;
  end

  assign hold_full  = (hold_cnt == REP_C);
  assign repeat_hit = chg_key & tick & hold_full;
  assign fire       = chg_rise | repeat_hit;

  AST_REPEAT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !chg_rise) |-> tick); // R7
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_key |=> (hold_cnt == '0)); // R8
  AST_PRESS_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    chg_rise |-> !hold_full); // R8
endmodule

// File: rtl/setkey_ctrl.sv
module setkey_ctrl
  import clkset_pkg::*;
#(
  parameter int REPEAT_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode_key,
  input  logic       sel_key,
  input  logic       chg_key,
  output logic [1:0] mode,
  output logic       led_hour,
  output logic       led_min,
  output logic       time_hr_inc,
  output logic       time_min_inc,
  output logic       alarm_hr_inc,
  output logic       alarm_min_inc,
  output logic       sec_clear
);
  logic [2:0] key_rise;
  logic       mode_rise, sel_rise, chg_rise;
  mode_e      mode_q;
  logic       fld_min_q;
  logic       fire;
  strobe_t    strobe_q;
  logic       sec_clear_q;

  key_edge #(.N(3)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .keys ({chg_key, sel_key, mode_key}),
    .rise (key_rise)
  );
  assign mode_rise = key_rise[0];
  assign sel_rise  = key_rise[1];
  assign chg_rise  = key_rise[2];

  mode_field u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_rise(mode_rise),
    .sel_rise (sel_rise),
    .mode_q   (mode_q),
    .fld_min_q(fld_min_q),
    .led_hour (led_hour),
    .led_min  (led_min)
  );

  repeat_gen #(.REPEAT_TICKS(REPEAT_TICKS)) u_rep (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .chg_key (chg_key),
    .chg_rise(chg_rise),
    .fire    (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q    <= '0;
      sec_clear_q <= 1'b0;
    end else begin
      strobe_q    <= route(mode_q, fld_min_q, fire);
      sec_clear_q <= (mode_q == MD_RUN) & sel_key;
    end
  end

  assign mode          = mode_q;
  assign time_hr_inc   = strobe_q.time_hr;
  assign time_min_inc  = strobe_q.time_min;
  assign alarm_hr_inc  = strobe_q.alarm_hr;
  assign alarm_min_inc = strobe_q.alarm_min;
  assign sec_clear     = sec_clear_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_q)); // R11
  AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RUN) |=> (strobe_q == '0)); // R9
  AST_SECCLR_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MD_RUN) |=> !sec_clear); // R10
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_rise && mode_q != MD_RUN && !tick) |=> ($countones(strobe_q) == 1)); // R6
endmodule

// File: tb/setkey_ctrl_tb.sv
module setkey_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int REP   = 3;

  logic clk = 1'b0;
  logic rst_n, tick, mode_key, sel_key, chg_key;
  logic [1:0] mode;
  logic led_hour, led_min, time_hr_inc, time_min_inc, alarm_hr_inc, alarm_min_inc, sec_clear;

  int checks = 0;
  int errors = 0;
  int exp_mode = 0;
  logic exp_fld = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  setkey_ctrl #(.REPEAT_TICKS(REP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .mode_key(mode_key), .sel_key(sel_key), .chg_key(chg_key),
    .mode(mode), .led_hour(led_hour), .led_min(led_min),
    .time_hr_inc(time_hr_inc), .time_min_inc(time_min_inc),
    .alarm_hr_inc(alarm_hr_inc), .alarm_min_inc(alarm_min_inc),
    .sec_clear(sec_clear)
  );

  function automatic logic [3:0] strobes();
    return {time_hr_inc, time_min_inc, alarm_hr_inc, alarm_min_inc};
  endfunction

  function automatic logic [3:0] want(int m, logic f);
    if (m == 1) return f ? 4'b0001 : 4'b0010;
    if (m == 2) return f ? 4'b0100 : 4'b1000;
    return 4'b0000;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    cyc();
    tick = 1'b0;
  endtask

  task automatic press_mode();
    mode_key = 1'b1; cyc(); mode_key = 1'b0; cyc();
    exp_mode = (exp_mode + 1) % 3;
  endtask

  task automatic press_sel();
    sel_key = 1'b1; cyc(); sel_key = 1'b0; cyc();
    exp_fld = ~exp_fld;
  endtask

  task automatic set_state(int m, logic f);
    while (exp_mode != m) press_mode();
    if (exp_fld != f) press_sel();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick = 0; mode_key = 0; sel_key = 0; chg_key = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1", "mode", 32'(mode), 0);
    chk("R1", "leds", 32'({led_hour, led_min}), 0);
    chk("R1", "strobes", 32'(strobes()), 0);
    chk("R1", "sec_clear", 32'(sec_clear), 0);
  endtask

  task automatic t_mode_cycle();
    mode_key = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R2", "held mode key advances once", 32'(mode), 1);
    end
    mode_key = 1'b0; cyc();
    exp_mode = 1;
    press_mode(); chk("R2", "mode 1->2", 32'(mode), 2);
    press_mode(); chk("R2", "mode 2->0", 32'(mode), 0);
  endtask

  task automatic t_select_leds();
    chk("R4", "run leds dark", 32'({led_hour, led_min}), 0);
    press_mode();
    chk("R4", "alarm hour led", 32'({led_hour, led_min}), 32'b10);
    press_sel();
    chk("R3", "select toggles to minutes", 32'({led_hour, led_min}), 32'b01);
    press_mode();
    chk("R4", "time-set minute led", 32'({led_hour, led_min}), 32'b01);
    press_sel();
    chk("R3", "select toggles to hours", 32'({led_hour, led_min}), 32'b10);
    press_mode();
    chk("R4", "run leds dark again", 32'({led_hour, led_min}), 0);
  endtask

  task automatic t_routing();
    for (int m = 1; m <= 2; m++) begin
      for (int f = 0; f <= 1; f++) begin
        set_state(m, f[0]);
        chg_key = 1'b1; cyc();
        chk("R5", $sformatf("route m%0d f%0d", m, f), 32'(strobes()), 32'(want(m, f[0])));
        cyc();
        chk("R6", "strobe lasts one cycle", 32'(strobes()), 0);
        chg_key = 1'b0; cyc();
      end
    end
  endtask

  task automatic t_hold_repeat();
    logic [3:0] w;
    set_state(2, 1'b1);
    w = want(2, 1'b1);
    chg_key = 1'b1; cyc();
    chk("R6", "first press strobe", 32'(strobes()), 32'(w));
    for (int i = 0; i < REP; i++) begin
      pulse_tick();
      chk("R7", $sformatf("no repeat at tick %0d", i + 1), 32'(strobes()), 0);
      cyc();
    end
    for (int i = 0; i < 3; i++) begin
      pulse_tick();
      chk("R7", "repeat on tick", 32'(strobes()), 32'(w));
      cyc();
      chk("R7", "no strobe without tick", 32'(strobes()), 0);
    end
    chg_key = 1'b0; cyc(); cyc();
    chg_key = 1'b1; cyc();
    chk("R8", "repress single strobe", 32'(strobes()), 32'(w));
    pulse_tick();
    chk("R8", "hold count restarted", 32'(strobes()), 0);
    cyc();
    chg_key = 1'b0; cyc();
  endtask

  task automatic t_run_quiet();
    set_state(0, exp_fld);
    chg_key = 1'b1; cyc();
    chk("R9", "run press quiet", 32'(strobes()), 0);
    for (int i = 0; i < REP + 3; i++) begin
      pulse_tick();
      chk("R9", "run hold quiet", 32'(strobes()), 0);
    end
    chg_key = 1'b0; cyc();
  endtask

  task automatic t_sec_clear();
    set_state(0, exp_fld);
    sel_key = 1'b1; cyc();
    exp_fld = ~exp_fld;
    for (int i = 0; i < 3; i++) begin
      chk("R10", "held select clears seconds", 32'(sec_clear), 1);
      cyc();
    end
    sel_key = 1'b0; cyc();
    chk("R10", "release ends clear", 32'(sec_clear), 0);
    press_mode();
    sel_key = 1'b1; cyc(); cyc();
    chk("R10", "no clear in alarm set", 32'(sec_clear), 0);
    sel_key = 1'b0; cyc();
    exp_fld = ~exp_fld;
  endtask

  initial begin
    t_reset();
    t_mode_cycle();
    t_select_leds();
    t_routing();
    t_hold_repeat();
    t_run_quiet();
    t_sec_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule